// File: doc/BRIEF.md
# Four-Bank SDRAM Command Decoder and Bank Tracker

This block watches the control pins of an SDRAM device on each rising clock edge, turns the pin pattern into a compact command code, and keeps a live picture of four internal banks: which are open, the row held open in each, and which have a self-closing precharge pending after a burst. It sits next to a memory controller or a memory model. There it serves as a protocol monitor and state source, so that downstream logic does not have to decode pins or track bank state itself.

The address bit at position 10 changes meaning with the command. On a read or write it asks for the addressed bank to close by itself once the burst has run. On a precharge it widens the close from one bank to all four. Accesses that break bank rules raise a one-cycle error flag, and such a command leaves bank state untouched. The rule-breaking cases are reading or writing a bank that is closed or already closing, opening a bank that is already open, and refreshing while any bank is open.

All outputs are registered. The effect of a command sampled at edge k is visible on the outputs just after edge k. The block carries no data path, so it has no flow-controlled stream interface; every pin is a plain level.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When clock enable is high and chip select is low, the pins {ras_n,cas_n,we_n} are decoded to cmd_code as follows: 011 activate gives 1, 101 read gives 2, 100 write gives 3, 010 precharge gives 4, 001 refresh gives 5, 000 mode set gives 6. Both 111 and 110 give 0 (no-op), and mode set and no-op report cmd_banks = 0.
- R2: With chip select high or clock enable low, cmd_code is 0, cmd_banks is 0, cmd_err is 0, and no bank opens or closes because of the pins.
- R3: An activate to a closed bank sets its bank_open bit and latches addr[11:0] into that bank's slice of bank_row (bank i at bits 12*i+11..12*i). cmd_banks is the one-hot bit 1<<ba.
- R4: An activate to an open bank pulses cmd_err and leaves that bank's row and open bit unchanged.
- R5: A read or write to a closed bank, or to a bank with bank_ap set, pulses cmd_err and changes no bank state.
- R6: A legal read or write with addr[10] high sets bank_ap for the addressed bank. The bank then closes on the BURST_LEN-th clock-enabled edge after the command, and bank_ap clears at the same edge. A legal access with addr[10] low changes no state.
- R7: The pending countdown keeps running across cycles with chip select high, and it holds still on every edge where clock enable is low.
- R8: A precharge with addr[10] high closes all four banks and clears their bank_ap bits, and reports cmd_banks = 1111 whatever the bank bits are. With addr[10] low it closes only bank ba and reports 1<<ba. A precharge of a closed bank is legal.
- R9: A refresh with all banks closed is accepted with cmd_banks = 1111. With any bank open it pulses cmd_err and changes nothing.
- R10: Reset clears every output. cmd_err is high only in the cycle that reports the offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low means no command is taken and countdowns freeze |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row on activate; column and auto-close bit 10 on access; all-bank bit 10 on precharge |
| cmd_code | output | 3 | Decoded command of the last edge |
| cmd_banks | output | 4 | Banks the last command addressed, bit i for bank i |
| cmd_err | output | 1 | One-cycle flag for an illegal command |
| bank_open | output | 4 | Open flag per bank |
| bank_row | output | 48 | Latched row per bank, 12 bits each |
| bank_ap | output | 4 | Auto-close pending per bank |

## Verification
The assertions assume that reset is held low across at least one rising edge before any command, and that all pins carry known 0/1 values at every sampled edge. They also take for granted that the bank selector always names one of the four banks. The stimulus changes pins only on falling edges and always drives full, defined pin patterns, including patterns sent while chip select is high or clock enable is low. A behavioural model with per-bank arrays and a remaining-cycles count predicts every output, and the bench compares the prediction after each edge.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } cmd_e;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (cke && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
  parameter int ROW_W     = 12,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             act_i,
  input  logic             close_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             ap_o
);
  localparam int CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  logic             open_q, ap_q;
  logic [ROW_W-1:0] row_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ap_q   <= 1'b0;
      row_q  <= '0;
      cnt_q  <= '0;
    end else if (close_i) begin
      open_q <= 1'b0;
      ap_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (ap_i) begin
      ap_q  <= 1'b1;
      cnt_q <= CW'(BURST_LEN - 1);
    end else if (tick && ap_q) begin
      if (cnt_q == '0) begin
        open_q <= 1'b0;
        ap_q   <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;
  assign ap_o   = ap_q;

  // R4
  act_closed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> !open_q);
  // R6
  ap_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_q |-> open_q);
  // R7
  frozen_when_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !close_i && !act_i && !ap_i) |=> $stable({open_q, ap_q, cnt_q, row_q}));
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int BANK_W    = 2,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cke,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic [BANK_W-1:0]             ba,
  input  logic [ROW_W-1:0]              addr,
  output logic [2:0]                    cmd_code,
  output logic [(1<<BANK_W)-1:0]        cmd_banks,
  output logic                          cmd_err,
  output logic [(1<<BANK_W)-1:0]        bank_open,
  output logic [(1<<BANK_W)*ROW_W-1:0]  bank_row,
  output logic [(1<<BANK_W)-1:0]        bank_ap
);
  localparam int NB = 1 << BANK_W;

  cmd_e          cmd;
  logic [NB-1:0] sel, act_v, close_v, ap_v, mask_n;
  logic          err_n;
  cmd_e          cmd_q;
  logic [NB-1:0] mask_q;
  logic          err_q;

  sdcmd_decode u_dec (
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  assign sel = NB'(1) << ba;

  always_comb begin
    act_v   = '0;
    close_v = '0;
    ap_v    = '0;
    mask_n  = '0;
    err_n   = 1'b0;
    unique case (cmd)
      CMD_ACT: begin
        mask_n = sel;
        if (|(bank_open & sel)) err_n = 1'b1;
        else                    act_v = sel;
      end
      CMD_RD, CMD_WR: begin
        mask_n = sel;
        if (!(|(bank_open & sel)) || (|(bank_ap & sel))) err_n = 1'b1;
        else if (addr[AP_BIT])                             ap_v  = sel;
      end
      CMD_PRE: begin
        mask_n  = addr[AP_BIT] ? {NB{1'b1}} : sel;
        close_v = mask_n;
      end
      CMD_REF: begin
        mask_n = {NB{1'b1}};
        if (|bank_open) err_n = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd;
      mask_q <= mask_n;
      err_q  <= err_n;
    end
  end

  assign cmd_code  = cmd_q;
  assign cmd_banks = mask_q;
  assign cmd_err   = err_q;

  for (genvar i = 0; i < NB; i++) begin : g_bank
    sdcmd_bank #(.ROW_W(ROW_W), .BURST_LEN(BURST_LEN)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (cke),
      .act_i   (act_v[i]),
      .close_i (close_v[i]),
      .ap_i    (ap_v[i]),
      .row_i   (addr),
      .open_o  (bank_open[i]),
      .row_o   (bank_row[i*ROW_W +: ROW_W]),
      .ap_o    (bank_ap[i])
    );
  end

  // R2
  gated_is_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke || cs_n) |=> (cmd_code == 3'd0 && cmd_banks == '0 && !cmd_err));
  // R3
  act_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd1) |-> ($countones(cmd_banks) == 1));
  // R8
  pre_all_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd4 && cmd_banks == {NB{1'b1}}) |-> (bank_open == '0 && bank_ap == '0));
  // R9
  ref_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd5 && !cmd_err) |-> (bank_open == '0));
  // R10
  err_only_on_checked_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (cmd_code inside {3'd1, 3'd2, 3'd3, 3'd5}));
  // R4
  err_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err && cmd_code == 3'd1) |-> $stable(bank_row));
endmodule

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;
  localparam int BL = 4;

  logic        clk = 1'b0;
  logic        rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [2:0]  cmd_code;
  logic [3:0]  cmd_banks, bank_open, bank_ap;
  logic        cmd_err;
  logic [47:0] bank_row;

  int checks = 0;
  int fails  = 0;

  // reference state
  bit  m_open[4];
  int  m_row[4];
  bit  m_ap[4];
  int  m_left[4];
  int  e_code, e_mask;
  bit  e_err;

  always #2 clk = ~clk;

  sdram_cmd_tracker #(.BURST_LEN(BL)) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_code(cmd_code), .cmd_banks(cmd_banks), .cmd_err(cmd_err),
    .bank_open(bank_open), .bank_row(bank_row), .bank_ap(bank_ap)
  );

  localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                         P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000,
                         P_NOP = 3'b111, P_BST = 3'b110;

  task automatic chk(string tag, string field, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, field, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "cmd_code", int'(cmd_code), e_code);
    chk(tag, "cmd_banks", int'(cmd_banks), e_mask);
    chk(tag, "cmd_err", int'(cmd_err), int'(e_err));
    for (int i = 0; i < 4; i++) begin
      chk(tag, "bank_open", int'(bank_open[i]), int'(m_open[i]));
      chk(tag, "bank_ap", int'(bank_ap[i]), int'(m_ap[i]));
      if (m_open[i]) chk(tag, "bank_row", int'(bank_row[i*12 +: 12]), m_row[i]);
    end
  endtask

  // drive at a falling edge, predict, then compare at the next falling edge
  task automatic cyc(string tag, bit k, bit cs, logic [2:0] pins, int b, int a);
    bit pre_ap[4];
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = pins;
    ba = 2'(b); addr = 12'(a);
    e_code = 0; e_mask = 0; e_err = 0;
    for (int i = 0; i < 4; i++) pre_ap[i] = m_ap[i];
    if (k && !cs) begin
      case (pins)
        P_ACT: e_code = 1; P_RD: e_code = 2; P_WR: e_code = 3;
        P_PRE: e_code = 4; P_REF: e_code = 5; P_MRS: e_code = 6;
        default: e_code = 0;
      endcase
    end
    case (e_code)
      1: begin
        e_mask = 1 << b;
        if (m_open[b]) e_err = 1;
        else begin m_open[b] = 1; m_row[b] = a & 12'hfff; end
      end
      2, 3: begin
        e_mask = 1 << b;
        if (!m_open[b] || m_ap[b]) e_err = 1;
        else if (a[10]) begin m_ap[b] = 1; m_left[b] = BL; end
      end
      4: begin
        e_mask = a[10] ? 15 : (1 << b);
        for (int i = 0; i < 4; i++)
          if (e_mask[i]) begin m_open[i] = 0; m_ap[i] = 0; end
      end
      5: begin
        e_mask = 15;
        if (m_open[0] || m_open[1] || m_open[2] || m_open[3]) e_err = 1;
      end
      default: ;
    endcase
    if (k) begin
      for (int i = 0; i < 4; i++)
        if (pre_ap[i] && m_ap[i]) begin
          m_left[i]--;
          if (m_left[i] == 0) begin m_open[i] = 0; m_ap[i] = 0; end
        end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic nop(string tag, int n);
    for (int j = 0; j < n; j++) cyc(tag, 1, 0, P_NOP, 0, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; cke = 1; cs_n = 1; {ras_n, cas_n, we_n} = P_NOP; ba = 0; addr = 0;
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; m_ap[i] = 0; m_left[i] = 0; end
    e_code = 0; e_mask = 0; e_err = 0;
    repeat (3) @(negedge clk);
    compare("R10_reset");
    chk("R10_reset", "bank_row", int'(bank_row[11:0]), 0);
    rst_n = 1;

    // R1 decode of non-bank commands
    cyc("R1_mrs", 1, 0, P_MRS, 0, 12'h033);
    cyc("R1_nop", 1, 0, P_NOP, 1, 0);
    cyc("R1_bst", 1, 0, P_BST, 2, 0);
    // R9 refresh with all closed
    cyc("R9_ref_ok", 1, 0, P_REF, 0, 0);
    // R3 activates
    cyc("R3_act0", 1, 0, P_ACT, 0, 12'h123);
    cyc("R3_act2", 1, 0, P_ACT, 2, 12'hABC);
    // R4 activate of an open bank
    cyc("R4_act_open", 1, 0, P_ACT, 0, 12'h555);
    nop("R10_err_drop", 1);
    // R5 access to closed bank
    cyc("R5_rd_closed", 1, 0, P_RD, 1, 12'h010);
    cyc("R5_wr_closed", 1, 0, P_WR, 3, 12'h010);
    // R6 plain accesses keep state
    cyc("R6_rd_plain", 1, 0, P_RD, 0, 12'h00F);
    cyc("R6_wr_plain", 1, 0, P_WR, 2, 12'h3FF);
    // R9 refresh while open
    cyc("R9_ref_busy", 1, 0, P_REF, 0, 0);
    // R6 auto-close countdown and R5 access while closing
    cyc("R6_rd_ap", 1, 0, P_RD, 0, 12'h404);
    cyc("R5_rd_closing", 1, 0, P_RD, 0, 12'h004);
    nop("R6_countdown", BL);
    // R7 countdown across chip select high and clock enable low
    cyc("R3_act1", 1, 0, P_ACT, 1, 12'h777);
    cyc("R6_wr_ap", 1, 0, P_WR, 1, 12'h400);
    cyc("R7_cs_high", 1, 1, P_ACT, 3, 12'h111);
    cyc("R7_cke_low", 0, 0, P_ACT, 3, 12'h222);
    cyc("R7_cke_low", 0, 0, P_PRE, 1, 12'h400);
    cyc("R7_cke_low", 0, 1, P_NOP, 0, 0);
    cyc("R7_resume", 1, 0, P_NOP, 0, 0);
    cyc("R7_resume", 1, 0, P_NOP, 0, 0);
    cyc("R7_resume", 1, 0, P_NOP, 0, 0);
    // R2 ignored commands leave bank 3 closed
    cyc("R2_cs_high_act", 1, 1, P_ACT, 3, 12'h999);
    cyc("R2_cke_low_act", 0, 0, P_ACT, 3, 12'h999);
    cyc("R2_after", 1, 0, P_RD, 3, 0);
    // R8 single-bank and all-bank precharge
    cyc("R3_act0b", 1, 0, P_ACT, 0, 12'h0F0);
    cyc("R3_act3", 1, 0, P_ACT, 3, 12'hFFF);
    cyc("R8_pre_one", 1, 0, P_PRE, 2, 12'h000);
    cyc("R8_pre_closed", 1, 0, P_PRE, 2, 12'h000);
    cyc("R6_wr_ap3", 1, 0, P_WR, 3, 12'h401);
    cyc("R8_pre_all", 1, 0, P_PRE, 1, 12'h400);
    cyc("R9_ref_after", 1, 0, P_REF, 2, 0);
    // R6 auto-close then re-open
    cyc("R3_act2b", 1, 0, P_ACT, 2, 12'h246);
    cyc("R6_rd_ap2", 1, 0, P_RD, 2, 12'h7FF);
    cyc("R4_act_closing", 1, 0, P_ACT, 2, 12'h001);
    nop("R6_countdown2", BL);
    cyc("R3_reopen", 1, 0, P_ACT, 2, 12'h864);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule